// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block holds a set of address translations and resolves one lookup per clock. Each slot stores a tag word (virtual page bits with a 13-bit context in its low bits) and a translation word that carries the valid flag, a page-size code, the physical page frame and the permission flags. A lookup presents a 64-bit virtual address, an access kind, the requester's privilege and a context selector. One clock later the block reports one of four outcomes: a translation with a 41-bit physical address and permissions, a miss, a data fault or a protection fault. A separate write port fills slots. Replacement choice and refill are left to the surrounding logic.

Each slot masks its own compare according to its page size, so 8 KiB, 64 KiB, 512 KiB and 4 MiB pages share the one array. A slot marked global matches under any context. A fault loads a status word with the reasons for the fault. A three-state machine keeps the valid and overflow flags of that word. In FS_EMPTY no fault is held. A fault moves it to FS_LOGGED. A second fault taken before a clear moves it to FS_OVERRUN, and further faults keep it there. A clear returns FS_LOGGED or FS_OVERRUN to FS_EMPTY. A clear that arrives in the same cycle as a fault leads to FS_LOGGED. Misses and faults also load a tag-access register with the page address and the context that was in use.

Top module: `tlb_xlate_top`

## Requirements
- R1: After reset there is no response, the status word and the tag-access register read zero, and every slot is invalid, so a lookup with translation enabled misses.
- R2: A write to index i stores the tag and the translation word in slot i. Translation-word fields are: bit 63 valid, [62:61] page size, bit 60 no-fault-only, bit 41 used, [40:13] frame, bit 3 side-effect, bit 2 privileged, bit 1 writable, bit 0 global. A lookup that matches a valid slot answers with rsp_hit one cycle later, and exactly one of hit, miss, data fault or protection fault is reported per lookup.
- R3: Page-size code 0, 1, 2 or 3 selects 8 KiB, 64 KiB, 512 KiB or 4 MiB. The address bits below the page size are left out of the compare and pass straight into the physical address. The frame bits above the page size come from the translation word, and physical address bits [12:0] always equal VA[12:0].
- R4: The context selector picks the context: 0 is the primary context input, 1 is the secondary context input and 2 is the nucleus context (zero). A slot that is not global matches only when tag bits [12:0] equal the selected context. A global slot matches under any context.
- R5: When several slots match, the lowest-numbered slot supplies the result.
- R6: With translation disabled, every lookup is a hit, the physical address is VA[40:0], and the permissions are read+write for data kinds and execute for a fetch. Neither the status word nor the tag-access register changes.
- R7: Permissions (rsp_perm, bit 0 read, bit 1 write, bit 2 execute) on a hit are read plus the writable bit for access kinds 0 (read), 1 (write) and 3 (non-faulting load), and execute only for kind 2 (fetch).
- R8: Three checks give a data fault, and each sets its own status bit. A user access to a privileged page sets bit 7. A non-faulting load to a side-effect page sets bit 8. Any other kind that touches a no-fault-only page sets bit 11. Several of these bits can be set together.
- R9: A write to a page that is not writable, when no data fault applies, gives a protection fault with none of bits 7, 8 or 11 set.
- R10: On a fault the status word is rebuilt. Bit 0 is valid, bit 1 is overflow (set when valid was already set), bit 2 is set for a write, bit 3 is the privileged-mode input, [5:4] is the context type (0 primary, 1 secondary, 2 nucleus) and bit 24 is set for a non-faulting load. A clear empties the word. A clear in the same cycle as a fault logs the fault without overflow.
- R11: A miss or a fault loads the tag-access register with {VA[63:13], context}. A miss leaves the status word unchanged.
- R12: A hit with no fault sets the used bit (41) of that slot. rsp_tte returns the slot's word as it was before the lookup. A write to the same slot in the same cycle takes precedence over the used-bit update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation enable |
| priv_mode | input | 1 | Requester runs privileged (status bit 3) |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 6 | Slot index to write |
| wr_tag | input | 64 | Tag word to store |
| wr_tte | input | 64 | Translation word to store |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 non-faulting load |
| lk_user | input | 1 | Requester is in user mode |
| lk_ctx_sel | input | 2 | 0 primary, 1 secondary, 2 nucleus |
| fsr_clr | input | 1 | Empty the status word |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No slot matched |
| rsp_dfault | output | 1 | Data fault |
| rsp_prot | output | 1 | Protection fault |
| rsp_pa | output | 41 | Physical address |
| rsp_perm | output | 3 | {execute, write, read} |
| rsp_tte | output | 64 | Matched slot word before the lookup |
| fsr | output | 25 | Fault status word |
| tag_access | output | 64 | Page address and context of the last miss or fault |

## Verification
Two pairs of events can land in the same cycle. The first pair is a status clear and a new fault. The bench raises fsr_clr on the same edge as a faulting lookup while the word is already valid. It then expects the new fault's bits with valid set and overflow clear. A later fault with no clear must set overflow. The second pair is a clean hit and a slot write to the same index. The bench writes a fresh word into a slot whose used bit is set, on the same edge as a hit to that slot. The hit must still return the old word with bit 41 set, and the next hit must show bit 41 cleared, which proves the write took precedence.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 64;
    localparam int CTX_W   = 13;
    localparam int PG_LSB  = 13;
    localparam int SZ_STEP = 3;
    localparam int STAT_W  = 25;

    // translation word fields
    localparam int TE_VALID = 63;
    localparam int TE_SZ_HI = 62;
    localparam int TE_SZ_LO = 61;
    localparam int TE_NFO   = 60;
    localparam int TE_USED  = 41;
    localparam int TE_SIDE  = 3;
    localparam int TE_PRIV  = 2;
    localparam int TE_WR    = 1;
    localparam int TE_GLOB  = 0;

    // status word fields
    localparam int ST_VALID   = 0;
    localparam int ST_OVF     = 1;
    localparam int ST_WRITE   = 2;
    localparam int ST_PMODE   = 3;
    localparam int ST_CT_LO   = 4;
    localparam int ST_CT_HI   = 5;
    localparam int ST_FT_PRIV = 7;
    localparam int ST_FT_SIDE = 8;
    localparam int ST_FT_NFO  = 11;
    localparam int ST_NFLD    = 24;

    typedef enum logic [1:0] {
        ACC_READ   = 2'd0,
        ACC_WRITE  = 2'd1,
        ACC_FETCH  = 2'd2,
        ACC_NFLOAD = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic priv_f;
        logic side_f;
        logic nfo_f;
    } fault_bits_t;

    // ones above the page offset of the given size code
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        int sh;
        sh = PG_LSB + SZ_STEP * int'(sz);
        return ~((64'd1 << sh) - 64'd1);
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [VA_W-1:0]                 wr_tag,
    input  logic [VA_W-1:0]                 wr_tte,
    input  logic                            use_en,
    input  logic [IDX_W-1:0]                use_idx,
    output logic [ENTRIES-1:0][VA_W-1:0]    tag_o,
    output logic [ENTRIES-1:0][VA_W-1:0]    tte_o
);
    logic [VA_W-1:0] tag_q [ENTRIES];
    logic [VA_W-1:0] tte_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[e] <= '0;
                tte_q[e] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                tag_q[e] <= wr_tag;
                tte_q[e] <= wr_tte;
            end else if (use_en && use_idx == IDX_W'(e)) begin
                tte_q[e][TE_USED] <= 1'b1;
            end
        end
        assign tag_o[e] = tag_q[e];
        assign tte_o[e] = tte_q[e];
    end

    // R2
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tte_o[$past(wr_idx)] == $past(wr_tte)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ENTRIES-1:0][VA_W-1:0]    tag_i,
    input  logic [ENTRIES-1:0][VA_W-1:0]    tte_i,
    input  logic [VA_W-1:0]                 va_i,
    input  logic [CTX_W-1:0]                ctx_i,
    output logic                            hit_any_o,
    output logic [IDX_W-1:0]                hit_idx_o,
    output logic [VA_W-1:0]                 hit_tte_o
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic [VA_W-1:0] msk;
        logic            ctx_ok;
        assign msk    = page_mask(tte_i[e][TE_SZ_HI:TE_SZ_LO]);
        assign ctx_ok = tte_i[e][TE_GLOB] || (tag_i[e][CTX_W-1:0] == ctx_i);
        assign hit_vec[e] = tte_i[e][TE_VALID] && ctx_ok
                         && (((va_i ^ tag_i[e]) & msk) == '0);
    end

    always_comb begin
        hit_idx_o = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (hit_vec[e]) hit_idx_o = IDX_W'(e);
        end
    end

    assign hit_any_o = |hit_vec;
    assign hit_tte_o = tte_i[hit_idx_o];

    // R5
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any_o |-> (hit_vec[hit_idx_o]
            && ((hit_vec & ((ENTRIES'(1) << hit_idx_o) - ENTRIES'(1))) == '0)));
endmodule

// File: rtl/tlb_fault_check.sv
module tlb_fault_check
    import tlb_pkg::*;
(
    input  logic        te_priv,
    input  logic        te_side,
    input  logic        te_nfo,
    input  logic        te_wr,
    input  acc_kind_e   kind_i,
    input  logic        user_i,
    output fault_bits_t fb_o,
    output logic        dfault_o,
    output logic        prot_o
);
    always_comb begin
        fb_o.priv_f = te_priv && user_i;
        fb_o.side_f = (kind_i == ACC_NFLOAD) && te_side;
        fb_o.nfo_f  = (kind_i != ACC_NFLOAD) && te_nfo;
        dfault_o    = fb_o.priv_f || fb_o.side_f || fb_o.nfo_f;
        prot_o      = !dfault_o && (kind_i == ACC_WRITE) && !te_wr;
    end
endmodule

// File: rtl/tlb_xlate_top.sv
module tlb_xlate_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PA_BITS = 41,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xlat_en,
    input  logic                priv_mode,
    input  logic [CTX_W-1:0]    pri_ctx,
    input  logic [CTX_W-1:0]    sec_ctx,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [VA_W-1:0]     wr_tag,
    input  logic [VA_W-1:0]     wr_tte,
    input  logic                lk_valid,
    input  logic [VA_W-1:0]     lk_va,
    input  logic [1:0]          lk_kind,
    input  logic                lk_user,
    input  logic [1:0]          lk_ctx_sel,
    input  logic                fsr_clr,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic                rsp_dfault,
    output logic                rsp_prot,
    output logic [PA_BITS-1:0]  rsp_pa,
    output logic [2:0]          rsp_perm,
    output logic [VA_W-1:0]     rsp_tte,
    output logic [STAT_W-1:0]   fsr,
    output logic [VA_W-1:0]     tag_access
);
    typedef enum logic [1:0] {FS_EMPTY, FS_LOGGED, FS_OVERRUN} fsr_state_e;

    fsr_state_e fs_q, fs_d;

    logic [ENTRIES-1:0][VA_W-1:0] tag_arr, tte_arr;
    logic                hit_any;
    logic [IDX_W-1:0]    hit_idx;
    logic [VA_W-1:0]     hit_tte;
    logic [CTX_W-1:0]    cur_ctx;
    logic [1:0]          ctx_type;
    acc_kind_e           kind;
    fault_bits_t         fbits;
    logic                dfault_c, prot_c;
    logic                lk_fire, good_hit, fault_ev, miss_ev;
    logic [PA_BITS-1:0]  pmask, pa_map;
    logic [2:0]          perm_c;
    logic [STAT_W-1:0]   det_new, det_q;

    assign kind = acc_kind_e'(lk_kind);

    always_comb begin
        unique case (lk_ctx_sel)
            2'd0:    begin cur_ctx = pri_ctx; ctx_type = 2'd0; end
            2'd1:    begin cur_ctx = sec_ctx; ctx_type = 2'd1; end
            default: begin cur_ctx = '0;      ctx_type = 2'd2; end
        endcase
    end

    tlb_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_tag  (wr_tag),
        .wr_tte  (wr_tte),
        .use_en  (lk_fire && good_hit),
        .use_idx (hit_idx),
        .tag_o   (tag_arr),
        .tte_o   (tte_arr)
    );

    tlb_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .tag_i     (tag_arr),
        .tte_i     (tte_arr),
        .va_i      (lk_va),
        .ctx_i     (cur_ctx),
        .hit_any_o (hit_any),
        .hit_idx_o (hit_idx),
        .hit_tte_o (hit_tte)
    );

    tlb_fault_check u_fchk (
        .te_priv  (hit_tte[TE_PRIV]),
        .te_side  (hit_tte[TE_SIDE]),
        .te_nfo   (hit_tte[TE_NFO]),
        .te_wr    (hit_tte[TE_WR]),
        .kind_i   (kind),
        .user_i   (lk_user),
        .fb_o     (fbits),
        .dfault_o (dfault_c),
        .prot_o   (prot_c)
    );

    // event decode and translated address
    always_comb begin
        lk_fire  = lk_valid && xlat_en;
        good_hit = hit_any && !dfault_c && !prot_c;
        fault_ev = lk_fire && hit_any && (dfault_c || prot_c);
        miss_ev  = lk_fire && !hit_any;
        pmask    = PA_BITS'(page_mask(hit_tte[TE_SZ_HI:TE_SZ_LO]));
        pa_map   = (hit_tte[PA_BITS-1:0] & pmask) | (lk_va[PA_BITS-1:0] & ~pmask);
        if (kind == ACC_FETCH) perm_c = 3'b100;
        else                   perm_c = {1'b0, (!xlat_en || hit_tte[TE_WR]), 1'b1};

        det_new                     = '0;
        det_new[ST_WRITE]           = (kind == ACC_WRITE);
        det_new[ST_PMODE]           = priv_mode;
        det_new[ST_CT_HI:ST_CT_LO]  = ctx_type;
        det_new[ST_FT_PRIV]         = fbits.priv_f;
        det_new[ST_FT_SIDE]         = fbits.side_f;
        det_new[ST_FT_NFO]          = fbits.nfo_f;
        det_new[ST_NFLD]            = (kind == ACC_NFLOAD);
    end

    // status state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= FS_EMPTY;
        else        fs_q <= fs_d;
    end

    // status next state
    always_comb begin
        fs_d = fs_q;
        unique case (fs_q)
            FS_EMPTY: begin
                if (fault_ev) fs_d = FS_LOGGED;
            end
            FS_LOGGED, FS_OVERRUN: begin
                if (fault_ev)     fs_d = fsr_clr ? FS_LOGGED : FS_OVERRUN;
                else if (fsr_clr) fs_d = FS_EMPTY;
            end
            default: fs_d = FS_EMPTY;
        endcase
    end

    // status outputs
    always_comb begin
        fsr = det_q;
        unique case (fs_q)
            FS_EMPTY:   ;
            FS_LOGGED:  fsr[ST_VALID] = 1'b1;
            FS_OVERRUN: begin
                fsr[ST_VALID] = 1'b1;
                fsr[ST_OVF]   = 1'b1;
            end
            default:    ;
        endcase
    end

    // status detail, tag access and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q      <= '0;
            tag_access <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_dfault <= 1'b0;
            rsp_prot   <= 1'b0;
            rsp_pa     <= '0;
            rsp_perm   <= '0;
            rsp_tte    <= '0;
        end else begin
            if (fault_ev)     det_q <= det_new;
            else if (fsr_clr) det_q <= '0;
            if (fault_ev || miss_ev)
                tag_access <= {lk_va[VA_W-1:PG_LSB], cur_ctx};
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_valid && (!xlat_en || good_hit);
            rsp_miss   <= miss_ev;
            rsp_dfault <= lk_fire && hit_any && dfault_c;
            rsp_prot   <= lk_fire && hit_any && prot_c;
            rsp_pa     <= xlat_en ? pa_map : lk_va[PA_BITS-1:0];
            rsp_perm   <= (lk_valid && (!xlat_en || good_hit)) ? perm_c : 3'b000;
            rsp_tte    <= lk_fire && hit_any ? hit_tte : '0;
        end
    end

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_dfault, rsp_prot}) == 1));

    // R10
    fault_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_dfault || rsp_prot)) |-> fsr[ST_VALID]);

    // R11
    miss_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss && !$past(fsr_clr)) |-> $stable(fsr));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_pa[PG_LSB-1:0] == $past(lk_va[PG_LSB-1:0])));
endmodule

// File: tb/tlb_xlate_top_bench.sv
module tlb_xlate_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b1, priv_mode = 1'b0;
    logic [12:0] pri_ctx = 13'd7, sec_ctx = 13'd8;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_tag = '0, wr_tte = '0;
    logic        lk_valid = 1'b0, lk_user = 1'b0, fsr_clr = 1'b0;
    logic [63:0] lk_va = '0;
    logic [1:0]  lk_kind = '0, lk_ctx_sel = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_dfault, rsp_prot;
    logic [40:0] rsp_pa;
    logic [2:0]  rsp_perm;
    logic [63:0] rsp_tte, tag_access;
    logic [24:0] fsr;

    int n_chk = 0, n_fail = 0;
    logic        co_clr = 1'b0, co_wr = 1'b0;
    logic [5:0]  co_widx = '0;
    logic [63:0] co_wtag = '0, co_wtte = '0;

    localparam logic [63:0] F_GLOB = 64'h1, F_WR = 64'h2, F_PRIV = 64'h4, F_SIDE = 64'h8;
    localparam logic [63:0] F_NFO  = 64'h1000_0000_0000_0000;
    localparam logic [63:0] PA_MSK = 64'h0000_01FF_FFFF_FFFF;
    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_FE = 2'd2, K_NF = 2'd3;
    localparam logic [1:0] S_PRI = 2'd0, S_SEC = 2'd1, S_NUC = 2'd2;

    localparam logic [63:0] VA_A = 64'h0000_1234_5678_A000;
    localparam logic [63:0] VA_B = 64'h0000_0040_0000_0000;
    localparam logic [63:0] VA_C = 64'h0000_0050_0001_0000;
    localparam logic [63:0] VA_D = 64'h0000_0060_0000_0000;
    localparam logic [63:0] VA_E = 64'h0000_0070_0000_0000;
    localparam logic [63:0] VA_F = 64'h0000_0080_0000_0000;
    localparam logic [63:0] VA_G = 64'h0000_0090_0000_0000;
    localparam logic [63:0] VA_H = 64'hABCD_0000_1234_5678;
    localparam logic [63:0] VA_J = 64'h0000_00A0_0000_0000;

    tlb_xlate_top u_tlb_xlate_top (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .priv_mode(priv_mode),
        .pri_ctx(pri_ctx), .sec_ctx(sec_ctx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_tte(wr_tte), .lk_valid(lk_valid), .lk_va(lk_va),
        .lk_kind(lk_kind), .lk_user(lk_user), .lk_ctx_sel(lk_ctx_sel),
        .fsr_clr(fsr_clr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_dfault(rsp_dfault), .rsp_prot(rsp_prot),
        .rsp_pa(rsp_pa), .rsp_perm(rsp_perm), .rsp_tte(rsp_tte), .fsr(fsr),
        .tag_access(tag_access)
    );

    always #4 clk = ~clk;

    function automatic logic [63:0] mk_tte(input logic [63:0] pa, input logic [1:0] sz,
                                           input logic [63:0] flags);
        return 64'h8000_0000_0000_0000 | (64'(sz) << 61)
             | (pa & 64'h0000_01FF_FFFF_E000) | flags;
    endfunction

    function automatic logic [63:0] mk_tag(input logic [63:0] va, input logic [12:0] ctx);
        return (va & ~64'h1FFF) | 64'(ctx);
    endfunction

    function automatic logic [63:0] exp_pa(input logic [63:0] tte, input logic [63:0] va);
        int sh;
        logic [63:0] m;
        sh = 13 + 3 * int'(tte[62:61]);
        m  = (64'd1 << sh) - 64'd1;
        return ((tte & ~m) | (va & m)) & PA_MSK;
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic write_slot(input logic [5:0] idx, input logic [63:0] tag, input logic [63:0] tte);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_tag = tag; wr_tte = tte;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_fsr();
        @(negedge clk);
        fsr_clr = 1'b1;
        @(negedge clk);
        fsr_clr = 1'b0;
    endtask

    task automatic lookup(input logic [63:0] va, input logic [1:0] kind,
                          input logic usr, input logic [1:0] sel);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_kind = kind; lk_user = usr; lk_ctx_sel = sel;
        if (co_clr) fsr_clr = 1'b1;
        if (co_wr) begin
            wr_en = 1'b1; wr_idx = co_widx; wr_tag = co_wtag; wr_tte = co_wtte;
        end
        @(negedge clk);
        lk_valid = 1'b0; fsr_clr = 1'b0; wr_en = 1'b0; co_clr = 1'b0; co_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R1 fsr after reset", 64'(fsr), 64'd0);
        chk("R1 tag_access after reset", tag_access, 64'd0);
        lookup(64'h0000_1000_0000_2000, K_RD, 1'b0, S_PRI);
        chk("R1 empty array misses", 64'(rsp_miss), 64'd1);
    endtask

    task automatic t_basic();
        logic [63:0] tte;
        tte = mk_tte(64'h1_2345_6000, 2'd0, F_WR);
        write_slot(6'd5, mk_tag(VA_A, 13'd7), tte);
        lookup(VA_A | 64'h123, K_RD, 1'b0, S_PRI);
        chk("R2 hit", 64'(rsp_hit), 64'd1);
        chk("R2 pa", 64'(rsp_pa), exp_pa(tte, VA_A | 64'h123));
        chk("R7 read perm on writable", 64'(rsp_perm), 64'd3);
    endtask

    task automatic t_sizes();
        write_slot(6'd9, mk_tag(VA_B, 13'd7), mk_tte(64'h1AC0_0000, 2'd3, 64'd0));
        lookup(VA_B + 64'h2A_B123, K_RD, 1'b0, S_PRI);
        chk("R3 4M hit", 64'(rsp_hit), 64'd1);
        chk("R3 4M pa", 64'(rsp_pa), 64'h1AEA_B123);
        write_slot(6'd10, mk_tag(VA_C, 13'd7), mk_tte(64'h0777_0000, 2'd1, 64'd0));
        lookup(VA_C + 64'hE456, K_RD, 1'b0, S_PRI);
        chk("R3 64K pa", 64'(rsp_pa), 64'h0777_E456);
        lookup(VA_C + 64'h1_0000, K_RD, 1'b0, S_PRI);
        chk("R3 64K outside page misses", 64'(rsp_miss), 64'd1);
        lookup(VA_A + 64'h2000, K_RD, 1'b0, S_PRI);
        chk("R3 8K bit13 differs misses", 64'(rsp_miss), 64'd1);
    endtask

    task automatic t_context();
        lookup(VA_A, K_RD, 1'b0, S_SEC);
        chk("R4 wrong context misses", 64'(rsp_miss), 64'd1);
        sec_ctx = 13'd7;
        lookup(VA_A, K_RD, 1'b0, S_SEC);
        chk("R4 secondary context hits", 64'(rsp_hit), 64'd1);
        sec_ctx = 13'd8;
        lookup(VA_A, K_RD, 1'b0, S_NUC);
        chk("R4 nucleus on local slot misses", 64'(rsp_miss), 64'd1);
        write_slot(6'd30, mk_tag(VA_D, 13'd3), mk_tte(64'h4000, 2'd0, F_GLOB));
        lookup(VA_D, K_RD, 1'b0, S_NUC);
        chk("R4 global under nucleus", 64'(rsp_hit), 64'd1);
        lookup(VA_D, K_RD, 1'b0, S_PRI);
        chk("R4 global under primary", 64'(rsp_hit), 64'd1);
    endtask

    task automatic t_priority();
        write_slot(6'd20, mk_tag(VA_E, 13'd7), mk_tte(64'h0AAA_A000, 2'd0, 64'd0));
        write_slot(6'd12, mk_tag(VA_E, 13'd7), mk_tte(64'h0BBB_C000, 2'd0, 64'd0));
        lookup(VA_E, K_RD, 1'b0, S_PRI);
        chk("R5 lower slot wins", 64'(rsp_pa), 64'h0BBB_C000);
        write_slot(6'd12, 64'd0, 64'd0);
        lookup(VA_E, K_RD, 1'b0, S_PRI);
        chk("R5 remaining slot answers", 64'(rsp_pa), 64'h0AAA_A000);
    endtask

    task automatic t_disabled();
        logic [24:0] f0;
        logic [63:0] ta0, va;
        va = 64'hFFFF_FEDC_BA98_7654;
        f0 = fsr; ta0 = tag_access;
        xlat_en = 1'b0;
        lookup(va, K_RD, 1'b1, S_PRI);
        chk("R6 bypass hit", 64'(rsp_hit), 64'd1);
        chk("R6 bypass pa", 64'(rsp_pa), va & PA_MSK);
        chk("R6 bypass data perm", 64'(rsp_perm), 64'd3);
        lookup(va, K_FE, 1'b1, S_PRI);
        chk("R6 bypass fetch perm", 64'(rsp_perm), 64'd4);
        chk("R6 status untouched", 64'(fsr), 64'(f0));
        chk("R6 tag access untouched", tag_access, ta0);
        xlat_en = 1'b1;
    endtask

    task automatic t_perms();
        lookup(VA_A, K_FE, 1'b0, S_PRI);
        chk("R7 fetch perm", 64'(rsp_perm), 64'd4);
        lookup(VA_A, K_WR, 1'b0, S_PRI);
        chk("R7 write perm", 64'(rsp_perm), 64'd3);
        lookup(VA_B, K_RD, 1'b0, S_PRI);
        chk("R7 read-only perm", 64'(rsp_perm), 64'd1);
    endtask

    task automatic t_faults();
        write_slot(6'd40, mk_tag(VA_F, 13'd7), mk_tte(64'h2000, 2'd0, F_PRIV | F_SIDE));
        write_slot(6'd41, mk_tag(VA_G, 13'd7), mk_tte(64'h6000, 2'd0, F_NFO));
        clear_fsr();
        lookup(VA_F, K_RD, 1'b1, S_PRI);
        chk("R8 user on priv page faults", 64'(rsp_dfault), 64'd1);
        chk("R8 priv status", 64'(fsr), 64'h81);
        lookup(VA_F, K_RD, 1'b0, S_PRI);
        chk("R8 supervisor read hits", 64'(rsp_hit), 64'd1);
        lookup(VA_F, K_NF, 1'b0, S_PRI);
        chk("R8 nf load on side-effect faults", 64'(rsp_dfault), 64'd1);
        chk("R8 side status with overflow", 64'(fsr), 64'h100_0103);
        clear_fsr();
        lookup(VA_G, K_FE, 1'b0, S_PRI);
        chk("R8 fetch on nfo page faults", 64'(rsp_dfault), 64'd1);
        chk("R8 nfo status", 64'(fsr), 64'h801);
        chk("R11 fault loads tag access", tag_access, mk_tag(VA_G, 13'd7));
    endtask

    task automatic t_prot();
        clear_fsr();
        lookup(VA_B, K_WR, 1'b0, S_PRI);
        chk("R9 write to read-only", 64'(rsp_prot), 64'd1);
        chk("R9 prot status", 64'(fsr), 64'h5);
        clear_fsr();
        lookup(VA_F, K_WR, 1'b1, S_PRI);
        chk("R9 data fault outranks prot", 64'({rsp_dfault, rsp_prot}), 64'd2);
        chk("R9 priv write status", 64'(fsr), 64'h85);
    endtask

    task automatic t_status();
        clear_fsr();
        chk("R10 clear empties", 64'(fsr), 64'd0);
        priv_mode = 1'b1; sec_ctx = 13'd7;
        lookup(VA_F, K_RD, 1'b1, S_SEC);
        chk("R10 mode and context type", 64'(fsr), 64'h99);
        co_clr = 1'b1;
        lookup(VA_F, K_RD, 1'b1, S_SEC);
        chk("R10 clear with fault no overflow", 64'(fsr), 64'h99);
        lookup(VA_F, K_RD, 1'b1, S_SEC);
        chk("R10 overflow", 64'(fsr), 64'h9B);
        priv_mode = 1'b0; sec_ctx = 13'd8;
    endtask

    task automatic t_miss();
        clear_fsr();
        lookup(VA_F, K_RD, 1'b1, S_PRI);
        lookup(VA_H, K_RD, 1'b0, S_SEC);
        chk("R11 miss", 64'(rsp_miss), 64'd1);
        chk("R11 tag access", tag_access, mk_tag(VA_H, 13'd8));
        chk("R11 status kept on miss", 64'(fsr), 64'h81);
    endtask

    task automatic t_used();
        logic [63:0] tte;
        tte = mk_tte(64'h8000, 2'd0, F_WR);
        write_slot(6'd50, mk_tag(VA_J, 13'd7), tte);
        lookup(VA_J, K_RD, 1'b0, S_PRI);
        chk("R12 first hit used clear", 64'(rsp_tte[41]), 64'd0);
        lookup(VA_J, K_RD, 1'b0, S_PRI);
        chk("R12 second hit used set", 64'(rsp_tte[41]), 64'd1);
        co_wr = 1'b1; co_widx = 6'd50; co_wtag = mk_tag(VA_J, 13'd7); co_wtte = tte;
        lookup(VA_J, K_RD, 1'b0, S_PRI);
        chk("R12 hit with write sees old", 64'(rsp_tte[41]), 64'd1);
        lookup(VA_J, K_RD, 1'b0, S_PRI);
        chk("R12 write wins over used", 64'(rsp_tte[41]), 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_sizes();
        t_context();
        t_priority();
        t_disabled();
        t_perms();
        t_faults();
        t_prot();
        t_status();
        t_miss();
        t_used();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule